// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment translation entries. Each slot holds two 64-bit words: an effective-segment word (the segment tag plus a valid bit) and a virtual-segment word (the segment-size field, a class bit and the virtual segment id). A dedicated lookup port takes an effective address and, one cycle later, reports whether a slot matches, which slot it was and that slot's virtual-segment word. Every lookup tries both supported segment sizes (256 MB and 1 TB) against each slot. Each slot's size field decides which of the two comparisons counts for that slot.

A separate command port carries the maintenance operations: a validated store into a slot, a read of either word of a slot, invalidate-all with a 3-bit hint, and invalidate-by-address in a local and a global form. Invalidations raise a one-cycle local or global flush request for the downstream translation caches. A mode input selects the newer hint policy for invalidate-all. Another input enables 1 TB segments. A third input selects 32-bit address mode for lookups.

Top module: `slb_array`

## Requirements
- R1: The segment word layout is: segment tag in bits [63:28] and valid flag in bit 27. A 256 MB entry has size field vsid[63:62] = 00. It hits a lookup when esid[63:28] equals ea[63:28], its valid bit is set and bits [26:0] other than the valid bit are zero.
- R2: A 1 TB entry (size field 01) hits when esid[63:40] equals ea[63:40], esid[39:28] and the other low bits are zero and the valid bit is set. A 256 MB tag that matches does not hit a 1 TB entry.
- R3: When several slots hit, the lowest-numbered slot is reported.
- R4: A lookup presented on a clock edge reports lk_done, lk_hit, lk_slot and lk_vsid after that edge. On a miss, lk_vsid is all ones and lk_slot is 0.
- R5: With lk_mode64 low, ea[63:32] is treated as zero for the lookup.
- R6: Command op 0 stores slot rb[11:0] with esid = rb with bits [11:0] cleared and vsid = rs. The store is rejected with cmd_err, and the table is left unchanged, if any of these holds: the slot is at or beyond the depth; any of rb[26:12] is set; rs[63] is set; or rs[63:62] = 01 while cfg_seg1t_en is low.
- R7: Command ops 1 and 2 return the segment word and the virtual-segment word of slot rb[11:0] in cmd_rdata. A slot at or beyond the depth gives cmd_err and a zero cmd_rdata.
- R8: Command op 3 (invalidate-all) always pulses flush_local. In the default policy it clears the valid bit of every slot from 1 upward and leaves slot 0 unchanged. The default policy applies when cfg_newmmu is low, and to hints 0, 1, 2, 5 and 6 when cfg_newmmu is high.
- R9: With cfg_newmmu high, hint 7 clears nothing, and hints 3 and 4 also clear slot 0. Hint 3 keeps every slot whose class bit vsid[7] is 0.
- R10: Command op 4 (local) or op 5 (global) clears the valid bit of the lowest slot that rb hits, and pulses flush_local or flush_global respectively. A miss pulses no flush and changes nothing.
- R11: A store and a lookup on the same edge: the lookup sees the table as it was before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_newmmu | input | 1 | Selects the newer invalidate-all hint policy |
| cfg_seg1t_en | input | 1 | Allows 1 TB segments to be stored |
| lk_valid | input | 1 | Lookup request |
| lk_mode64 | input | 1 | 1: full 64-bit address; 0: upper half cleared |
| lk_ea | input | 64 | Effective address to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_slot | output | 5 | Matching slot index (default depth 32) |
| lk_vsid | output | 64 | Virtual-segment word of the hit, all ones on miss |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 store, 1 read seg, 2 read vseg, 3 inval-all, 4 inval-addr local, 5 inval-addr global |
| cmd_rb | input | 64 | Slot/segment operand or invalidate address |
| cmd_rs | input | 64 | Virtual-segment word for a store |
| cmd_hint | input | 3 | Invalidate-all hint |
| cmd_done | output | 1 | Command completed |
| cmd_err | output | 1 | Command rejected as invalid |
| cmd_rdata | output | 64 | Read data |
| flush_local | output | 1 | One-cycle local flush request |
| flush_global | output | 1 | One-cycle global flush request |

## Verification
The assertions assume that commands arrive as single-cycle pulses with an op code in the range 0 to 5. They also assume that the configuration inputs are held steady while a command is in flight, since the flush and valid-bit properties compare one cycle against the next. The directed tasks drive each command for exactly one cycle, change the configuration only between commands and never issue an undefined op code. Entries with duplicate tags are created on purpose, so that the lowest-slot priority check is exercised.

// File: rtl/slb_pkg.sv
// Package: shared op codes and fixed field positions of the segment table.
// Assumes 64-bit segment and virtual-segment words.
package slb_pkg;
    localparam int WORD_W    = 64;
    localparam int VBIT      = 27;   // valid flag inside segment word
    localparam int SEG256_LO = 28;   // lowest tag bit for 256 MB segments
    localparam int SEG1T_LO  = 40;   // lowest tag bit for 1 TB segments
    localparam int SIZE_HI   = 63;   // size field vsid[63:62]
    localparam int CLASS_BIT = 7;    // class flag inside virtual-segment word
    localparam int SLOT_W    = 12;   // slot number width in rb

    typedef enum logic [2:0] {
        OP_STORE   = 3'd0,
        OP_RD_SEG  = 3'd1,
        OP_RD_VSEG = 3'd2,
        OP_INV_ALL = 3'd3,
        OP_INV_EA  = 3'd4,
        OP_INV_EAG = 3'd5
    } slb_op_e;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/slb_match.sv
// Module: per-slot dual-size tag comparison.
// Builds the 256 MB and 1 TB tags from the address (valid bit set) and
// flags every slot whose stored word equals the tag of its own size.
// Assumes size codes 00 = 256 MB and 01 = 1 TB; other codes never hit.
module slb_match #(
    parameter int DEPTH = 32
) (
    input  slb_pkg::word_t [DEPTH-1:0] seg_tbl,
    input  slb_pkg::word_t [DEPTH-1:0] vseg_tbl,
    input  slb_pkg::word_t             ea,
    output logic [DEPTH-1:0]           hit_vec
);
    import slb_pkg::*;

    word_t tag256;
    word_t tag1t;

    // Purpose: form the two search tags from the address.
    always_comb begin
        tag256 = '0;
        tag1t  = '0;
        tag256[WORD_W-1:SEG256_LO] = ea[WORD_W-1:SEG256_LO];
        tag1t[WORD_W-1:SEG1T_LO]   = ea[WORD_W-1:SEG1T_LO];
        tag256[VBIT] = 1'b1;
        tag1t[VBIT]  = 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic sz256;
        logic sz1t;
        // Purpose: compare slot i against the tag of its own size.
        always_comb begin
            sz256      = (vseg_tbl[i][SIZE_HI:SIZE_HI-1] == 2'b00);
            sz1t       = (vseg_tbl[i][SIZE_HI:SIZE_HI-1] == 2'b01);
            hit_vec[i] = (sz256 && (seg_tbl[i] == tag256)) ||
                         (sz1t  && (seg_tbl[i] == tag1t));
        end
    end
endmodule

// File: rtl/slb_prio.sv
// Module: lowest-index priority selector over a hit vector.
// Assumes any number of bits may be set; reports the smallest index.
module slb_prio #(
    parameter int DEPTH = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Purpose: scan downward so the lowest set bit is the last written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R3: the chosen slot hits and no lower slot does.
    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (vec[idx] && ((vec & ((DEPTH'(1) << idx) - DEPTH'(1))) == '0)));
endmodule

// File: rtl/slb_inval_sel.sv
// Module: chooses which slots invalidate-all clears.
// Default policy spares slot 0; the newer policy adds hint 7 (nothing),
// hints 3/4 (slot 0 included) and hint 3 (class-0 slots kept).
// Undefined hint 5 falls into the default policy.
module slb_inval_sel #(
    parameter int DEPTH = 32
) (
    input  logic             newmmu,
    input  logic [2:0]       hint,
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] cls,
    output logic [DEPTH-1:0] clr_mask
);
    logic skip_all;
    logic incl_zero;
    logic keep_cls0;

    // Purpose: decode the hint under the selected policy.
    always_comb begin
        skip_all  = newmmu && (hint == 3'd7);
        incl_zero = newmmu && ((hint == 3'd3) || (hint == 3'd4));
        keep_cls0 = newmmu && (hint == 3'd3);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        // Purpose: decide whether slot i loses its valid bit.
        always_comb begin
            clr_mask[i] = !skip_all && valid[i] &&
                          ((i != 0) || incl_zero) &&
                          !(keep_cls0 && !cls[i]);
        end
    end
endmodule

// File: rtl/slb_array.sv
// Module: top of the segment lookaside table.
// Holds DEPTH slot pairs, serves a registered lookup port and a
// registered command port (store, read, invalidations, flush pulses).
// Assumes single-cycle command pulses with op codes 0..5.
module slb_array #(
    parameter int DEPTH = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_newmmu,
    input  logic             cfg_seg1t_en,
    input  logic             lk_valid,
    input  logic             lk_mode64,
    input  logic [63:0]      lk_ea,
    output logic             lk_done,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_slot,
    output logic [63:0]      lk_vsid,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [63:0]      cmd_rb,
    input  logic [63:0]      cmd_rs,
    input  logic [2:0]       cmd_hint,
    output logic             cmd_done,
    output logic             cmd_err,
    output logic [63:0]      cmd_rdata,
    output logic             flush_local,
    output logic             flush_global
);
    import slb_pkg::*;

    word_t [DEPTH-1:0] seg_q;
    word_t [DEPTH-1:0] vseg_q;
    logic  [DEPTH-1:0] valid_vec;
    logic  [DEPTH-1:0] cls_vec;

    // Purpose: expose per-slot valid and class flags.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i] = seg_q[i][VBIT];
            cls_vec[i]   = vseg_q[i][CLASS_BIT];
        end
    end

    // ---- lookup path ----
    word_t             lk_addr;
    logic  [DEPTH-1:0] lk_hits;
    logic              lk_any;
    logic  [IDX_W-1:0] lk_idx;

    // Purpose: clear the upper address half in 32-bit mode.
    always_comb begin
        lk_addr = lk_mode64 ? lk_ea : {32'h0, lk_ea[31:0]};
    end

    slb_match #(.DEPTH(DEPTH)) u_lk_match (
        .seg_tbl(seg_q), .vseg_tbl(vseg_q), .ea(lk_addr), .hit_vec(lk_hits));
    slb_prio #(.DEPTH(DEPTH)) u_lk_prio (
        .clk(clk), .rst_n(rst_n), .vec(lk_hits), .any(lk_any), .idx(lk_idx));

    // ---- command path ----
    logic  [DEPTH-1:0] ea_hits;
    logic              ea_any;
    logic  [IDX_W-1:0] ea_idx;
    logic  [DEPTH-1:0] clr_mask;

    slb_match #(.DEPTH(DEPTH)) u_cmd_match (
        .seg_tbl(seg_q), .vseg_tbl(vseg_q), .ea(cmd_rb), .hit_vec(ea_hits));
    slb_prio #(.DEPTH(DEPTH)) u_cmd_prio (
        .clk(clk), .rst_n(rst_n), .vec(ea_hits), .any(ea_any), .idx(ea_idx));
    slb_inval_sel #(.DEPTH(DEPTH)) u_inv_sel (
        .newmmu(cfg_newmmu), .hint(cmd_hint), .valid(valid_vec),
        .cls(cls_vec), .clr_mask(clr_mask));

    logic              slot_ok;
    logic [IDX_W-1:0]  slot_idx;
    logic              st_bad;
    word_t             st_seg;
    slb_op_e           op;

    // Purpose: decode the slot operand and validate store operands.
    always_comb begin
        op       = slb_op_e'(cmd_op);
        slot_ok  = ({1'b0, cmd_rb[SLOT_W-1:0]} < (SLOT_W+1)'(DEPTH));
        slot_idx = cmd_rb[IDX_W-1:0];
        st_seg   = {cmd_rb[WORD_W-1:SLOT_W], {SLOT_W{1'b0}}};
        st_bad   = !slot_ok
                || (cmd_rb[VBIT-1:SLOT_W] != '0)
                || cmd_rs[SIZE_HI]
                || (cmd_rs[SIZE_HI:SIZE_HI-1] == 2'b01 && !cfg_seg1t_en);
    end

    // Purpose: update the table contents for stores and invalidations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            vseg_q <= '0;
        end else if (cmd_valid) begin
            case (op)
                OP_STORE: if (!st_bad) begin
                    seg_q[slot_idx]  <= st_seg;
                    vseg_q[slot_idx] <= cmd_rs;
                end
                OP_INV_ALL: begin
                    for (int i = 0; i < DEPTH; i++)
                        if (clr_mask[i]) seg_q[i][VBIT] <= 1'b0;
                end
                OP_INV_EA, OP_INV_EAG: if (ea_any) seg_q[ea_idx][VBIT] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Purpose: register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_slot <= '0;
            lk_vsid <= '1;
        end else begin
            lk_done <= lk_valid;
            lk_hit  <= lk_valid && lk_any;
            lk_slot <= (lk_valid && lk_any) ? lk_idx : '0;
            lk_vsid <= (lk_valid && lk_any) ? vseg_q[lk_idx] : '1;
        end
    end

    // Purpose: register command completion, errors, read data and flushes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done     <= 1'b0;
            cmd_err      <= 1'b0;
            cmd_rdata    <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            cmd_done     <= cmd_valid;
            cmd_err      <= 1'b0;
            cmd_rdata    <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
            if (cmd_valid) begin
                case (op)
                    OP_STORE:   cmd_err <= st_bad;
                    OP_RD_SEG: begin
                        cmd_err   <= !slot_ok;
                        cmd_rdata <= slot_ok ? seg_q[slot_idx] : '0;
                    end
                    OP_RD_VSEG: begin
                        cmd_err   <= !slot_ok;
                        cmd_rdata <= slot_ok ? vseg_q[slot_idx] : '0;
                    end
                    OP_INV_ALL: flush_local  <= 1'b1;
                    OP_INV_EA:  flush_local  <= ea_any;
                    OP_INV_EAG: flush_global <= ea_any;
                    default: cmd_err <= 1'b1;
                endcase
            end
        end
    end

    // ---- assertions ----
    assert_one_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_local && flush_global));

    assert_lk_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    assert_err_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);

    assert_hint7_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && cfg_newmmu && cmd_hint == 3'd7)
        |=> $stable(valid_vec));

    assert_slot0_spared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 &&
         !(cfg_newmmu && (cmd_hint == 3'd3 || cmd_hint == 3'd4)))
        |=> $stable(valid_vec[0]));

    assert_inval_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=> flush_local);
endmodule

// File: tb/slb_array_tb_top.sv
module slb_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_newmmu = 1'b0;
    logic        cfg_seg1t_en = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_mode64 = 1'b1;
    logic [63:0] lk_ea = '0;
    logic        lk_done, lk_hit;
    logic [4:0]  lk_slot;
    logic [63:0] lk_vsid;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_rb = '0;
    logic [63:0] cmd_rs = '0;
    logic [2:0]  cmd_hint = '0;
    logic        cmd_done, cmd_err, flush_local, flush_global;
    logic [63:0] cmd_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    slb_array #(.DEPTH(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_newmmu(cfg_newmmu), .cfg_seg1t_en(cfg_seg1t_en),
        .lk_valid(lk_valid), .lk_mode64(lk_mode64), .lk_ea(lk_ea),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsid(lk_vsid),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rb(cmd_rb), .cmd_rs(cmd_rs),
        .cmd_hint(cmd_hint), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .cmd_rdata(cmd_rdata), .flush_local(flush_local), .flush_global(flush_global));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rb256(input logic [63:0] ea, input int slot);
        return {ea[63:28], 1'b1, 15'h0, 12'(slot)};
    endfunction

    function automatic logic [63:0] rb1t(input logic [63:0] ea, input int slot);
        return {ea[63:40], 12'h0, 1'b1, 15'h0, 12'(slot)};
    endfunction

    // one-cycle command; outputs sampled on the following falling edge
    task automatic cmd(input logic [2:0] op, input logic [63:0] rb,
                       input logic [63:0] rs, input logic [2:0] hint);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_rb = rb; cmd_rs = rs; cmd_hint = hint;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [63:0] ea, input logic m64,
                        input logic exp_hit, input int exp_slot, input logic [63:0] exp_vsid);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea; lk_mode64 = m64;
        @(negedge clk);
        lk_valid = 1'b0; lk_mode64 = 1'b1;
        chk({req, " done"}, 64'(lk_done), 64'd1);
        chk({req, " hit"},  64'(lk_hit), 64'(exp_hit));
        chk({req, " slot"}, 64'(lk_slot), 64'(exp_slot));
        chk({req, " vsid"}, lk_vsid, exp_vsid);
    endtask

    localparam logic [63:0] EA_A = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] EA_B = 64'hABCD_EF12_3456_7890;
    localparam logic [63:0] EA_C = 64'h0000_0000_5000_0004;
    localparam logic [63:0] V_A  = 64'h0000_0000_00AB_C000;
    localparam logic [63:0] V_B  = 64'h4000_0000_0012_3000;
    localparam logic [63:0] V_C  = 64'h0000_0000_0777_0000;

    task automatic t_reset;
        chk("R4 reset lk_done", 64'(lk_done), 64'd0);
        chk("R10 reset flushes", 64'({flush_local, flush_global}), 64'd0);
        chk("R6 reset cmd_done", 64'(cmd_done), 64'd0);
        look("R4 reset miss", EA_A, 1'b1, 1'b0, 0, '1);
    endtask

    task automatic t_256m;
        cmd(3'd0, rb256(EA_A, 2), V_A, 3'd0);
        chk("R6 store ok", 64'(cmd_err), 64'd0);
        look("R1 256M hit", EA_A, 1'b1, 1'b1, 2, V_A);
        look("R1 other offset", {EA_A[63:28], 28'h0000123}, 1'b1, 1'b1, 2, V_A);
        look("R4 miss", EA_A ^ 64'h0000_0000_1000_0000, 1'b1, 1'b0, 0, '1);
    endtask

    task automatic t_1t;
        cmd(3'd0, rb1t(EA_B, 5), V_B, 3'd0);
        chk("R2 store ok", 64'(cmd_err), 64'd0);
        look("R2 1T hit", EA_B, 1'b1, 1'b1, 5, V_B);
        look("R2 1T far offset", {EA_B[63:40], 40'hFF_FFFF_FFFF}, 1'b1, 1'b1, 5, V_B);
        // 256M-size entry with the same tag must not be seen as 1T match
        cmd(3'd0, rb256({EA_B[63:40], 40'h0}, 6), V_A, 3'd0);
        look("R2 size field selects", {EA_B[63:40], 40'h01_0000_0000}, 1'b1, 1'b1, 5, V_B);
    endtask

    task automatic t_prio;
        cmd(3'd0, rb256(EA_A, 7), V_C, 3'd0);
        look("R3 lowest slot", EA_A, 1'b1, 1'b1, 2, V_A);
    endtask

    task automatic t_mode32;
        cmd(3'd0, rb256(EA_C, 3), V_C, 3'd0);
        look("R5 32-bit clears upper", 64'hFFFF_FFFF_5000_0004, 1'b0, 1'b1, 3, V_C);
        look("R5 64-bit keeps upper", 64'hFFFF_FFFF_5000_0004, 1'b1, 1'b0, 0, '1);
    endtask

    task automatic t_store_err;
        cmd(3'd0, rb256(EA_C, 32), V_C, 3'd0);
        chk("R6 slot range", 64'(cmd_err), 64'd1);
        cmd(3'd0, rb256(EA_C, 9) | 64'h1000, V_C, 3'd0);
        chk("R6 reserved bit", 64'(cmd_err), 64'd1);
        cmd(3'd0, rb256(EA_C, 9), 64'h8000_0000_0000_0000, 3'd0);
        chk("R6 bad size", 64'(cmd_err), 64'd1);
        cfg_seg1t_en = 1'b0;
        cmd(3'd0, rb1t(EA_B, 9), V_B, 3'd0);
        chk("R6 1T disabled", 64'(cmd_err), 64'd1);
        cfg_seg1t_en = 1'b1;
        cmd(3'd2, 64'd9, '0, 3'd0);
        chk("R6 rejected store leaves slot", cmd_rdata, 64'd0);
    endtask

    task automatic t_read;
        cmd(3'd1, 64'd2, '0, 3'd0);
        chk("R7 read seg err", 64'(cmd_err), 64'd0);
        chk("R7 read seg", cmd_rdata, {EA_A[63:28], 1'b1, 27'h0});
        cmd(3'd2, 64'hFFFF_F000 | 64'd5, '0, 3'd0);
        chk("R7 read vseg", cmd_rdata, V_B);
        cmd(3'd1, 64'd40, '0, 3'd0);
        chk("R7 range err", 64'(cmd_err), 64'd1);
        chk("R7 range data", cmd_rdata, 64'd0);
    endtask

    task automatic t_same_cycle;
        logic [63:0] ea = 64'h0000_7700_0000_0000;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_rb = rb256(ea, 10); cmd_rs = V_C;
        lk_valid = 1'b1; lk_ea = ea; lk_mode64 = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; lk_valid = 1'b0;
        chk("R11 lookup sees old", 64'(lk_hit), 64'd0);
        look("R11 next lookup sees new", ea, 1'b1, 1'b1, 10, V_C);
    endtask

    task automatic t_inval_ea;
        cmd(3'd4, EA_C, '0, 3'd0);
        chk("R10 local flush", 64'({flush_local, flush_global}), 64'b10);
        look("R10 cleared", EA_C, 1'b1, 1'b0, 0, '1);
        cmd(3'd5, EA_B, '0, 3'd0);
        chk("R10 global flush", 64'({flush_local, flush_global}), 64'b01);
        look("R10 1T cleared", EA_B, 1'b1, 1'b0, 0, '1);
        cmd(3'd4, 64'h5555_0000_0000_0000, '0, 3'd0);
        chk("R10 miss no flush", 64'({flush_local, flush_global}), 64'b00);
        chk("R10 miss done", 64'(cmd_done), 64'd1);
    endtask

    task automatic t_inval_all;
        logic [63:0] e0 = 64'h0000_1000_0000_0000;
        logic [63:0] e1 = 64'h0000_2000_0000_0000;
        logic [63:0] e4 = 64'h0000_4000_0000_0000;
        logic [63:0] vc1 = 64'h0000_0000_0000_0080;   // class bit set
        cmd(3'd0, rb256(e0, 0), 64'h100, 3'd0);
        cmd(3'd0, rb256(e1, 1), vc1, 3'd0);
        cmd(3'd0, rb256(e4, 4), 64'h400, 3'd0);
        cfg_newmmu = 1'b1;
        cmd(3'd3, '0, '0, 3'd7);
        chk("R9 hint7 flush", 64'(flush_local), 64'd1);
        look("R9 hint7 keeps s1", e1, 1'b1, 1'b1, 1, vc1);
        look("R9 hint7 keeps s4", e4, 1'b1, 1'b1, 4, 64'h400);
        cmd(3'd3, '0, '0, 3'd3);
        look("R9 hint3 keeps class0 s0", e0, 1'b1, 1'b1, 0, 64'h100);
        look("R9 hint3 clears class1", e1, 1'b1, 1'b0, 0, '1);
        look("R9 hint3 keeps class0 s4", e4, 1'b1, 1'b1, 4, 64'h400);
        cmd(3'd3, '0, '0, 3'd5);
        look("R9 hint5 as 0 keeps s0", e0, 1'b1, 1'b1, 0, 64'h100);
        look("R9 hint5 clears s4", e4, 1'b1, 1'b0, 0, '1);
        cmd(3'd3, '0, '0, 3'd4);
        look("R9 hint4 clears s0", e0, 1'b1, 1'b0, 0, '1);
        cfg_newmmu = 1'b0;
        cmd(3'd0, rb256(e0, 0), 64'h100, 3'd0);
        cmd(3'd0, rb256(e1, 1), vc1, 3'd0);
        cmd(3'd3, '0, '0, 3'd7);
        chk("R8 default flush", 64'({flush_local, flush_global}), 64'b10);
        look("R8 default keeps s0", e0, 1'b1, 1'b1, 0, 64'h100);
        look("R8 default clears s1", e1, 1'b1, 1'b0, 0, '1);
        cmd(3'd1, 64'd1, '0, 3'd0);
        chk("R8 valid bit cleared", cmd_rdata, {e1[63:28], 28'h0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_256m();
        t_1t();
        t_prio();
        t_mode32();
        t_store_err();
        t_read();
        t_same_cycle();
        t_inval_ea();
        t_inval_all();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule